// File: doc/BRIEF.md
# Clock Manager Auto-Relock Controller

This block watches several clock-manager or PLL instances and brings each one back to lock without help from software. Each instance supplies a lock indication and a small group of failure status bits. An instance needs service when its lock is low or any of its failure bits is high. A single shared sequencer visits the instances in turn. When it finds one that needs service, it sends that instance a reset pulse lasting exactly one supervisor clock. It then waits a fixed number of cycles before judging whether lock has come back.

If the instance is still unlocked or still faulted when the wait ends, the sequencer resets it again, and it keeps doing so for as long as needed. This covers a reset that fired while the reference clock was absent, which cannot produce lock. No clock-lost flag is consulted: only a confirmed lock with no failure bits ends the service of an instance. All inputs pass through two-flop synchronizers into the supervisor clock domain. For each instance, a saturating count of the reset pulses it has received is available as an output.

Top module: `relock_supervisor`

## Requirements
- R1: After reset, `mgr_rst` is all zero and every `retry_cnt` field is zero. While every instance has lock high and all failure bits low, no reset pulse is issued. The synchronized lock samples start out high.
- R2: Instance i has `N_FLT` failure bits at `fault_in[i*N_FLT +: N_FLT]`, and they are ORed together. Any single bit set on an otherwise locked instance causes that instance to be serviced.
- R3: A reset pulse is one-hot in `mgr_rst` (bit i resets instance i) and high for exactly one clock.
- R4: The result of a reset is judged `WAIT_CYC` cycles after the pulse. If the instance still needs service, its next pulse rises exactly `WAIT_CYC` cycles after the previous one. No two pulses are ever closer than `WAIT_CYC` cycles.
- R5: Resets to an instance are repeated without limit until it shows lock high and no failure bits at a judgement. After that, no further pulse is issued to it unless it needs service again.
- R6: After an instance is confirmed, scanning continues at the next index, wrapping from `N_INST-1` to 0. The first instance found needing service is serviced next.
- R7: `retry_cnt[i*CNT_W +: CNT_W]` counts the reset pulses issued to instance i. It saturates at 2^CNT_W-1 and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_in | input | N_INST | Lock indication per instance, asynchronous |
| fault_in | input | N_INST*N_FLT | Failure status bits, N_FLT per instance, asynchronous |
| mgr_rst | output | N_INST | One-clock reset pulse per instance |
| retry_cnt | output | N_INST*CNT_W | Saturating count of reset pulses per instance |

## Verification
The hardest situation to reach is an instance whose reference clock stays absent across several resets, while other instances lose lock during its retry loop. The stimulus uses a bench model of each instance that regains lock a few cycles after a reset only when its clock is marked present. One instance is held clockless through four resets, and two others drop lock while it is still being retried. Restoring its clock just before the fifth pulse then shows the fixed retry spacing, the saturation of its counter, and the wrap-around order in which the two waiting instances are served afterwards.

// File: rtl/relock_supervisor.sv
module relock_supervisor #(
  parameter int N_INST   = 4,
  parameter int N_FLT    = 3,
  parameter int WAIT_CYC = 4096,
  parameter int CNT_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_INST-1:0]         lock_in,
  input  logic [N_INST*N_FLT-1:0]   fault_in,
  output logic [N_INST-1:0]         mgr_rst,
  output logic [N_INST*CNT_W-1:0]   retry_cnt
);
  localparam int IW = (N_INST > 1) ? $clog2(N_INST) : 1;
  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_INST - 1);
  localparam logic [TW-1:0] T_END = TW'(WAIT_CYC - 1);

  typedef enum logic {SCAN, HOLD} st_t;

  logic [N_INST-1:0]       lk1, lk2, need;
  logic [N_INST*N_FLT-1:0] ft1, ft2;
  logic [IW-1:0]           idx, idx_nxt;
  logic [TW-1:0]           timer;
  logic [N_INST-1:0]       rst_q;
  st_t                     st;
  logic                    cur_need, judge, fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lk1 <= '1; lk2 <= '1; ft1 <= '0; ft2 <= '0;
    end else begin
      lk1 <= lock_in; lk2 <= lk1; ft1 <= fault_in; ft2 <= ft1;
    end

  for (genvar i = 0; i < N_INST; i++) begin : g_need
    assign need[i] = ~lk2[i] | (|ft2[i*N_FLT +: N_FLT]);
  end

  assign cur_need = need[idx];
  assign idx_nxt  = (idx == LAST_IDX) ? '0 : idx + 1'b1;
  assign judge    = (st == HOLD) && (timer == T_END);
  assign fire     = cur_need && ((st == SCAN) || judge);
  assign mgr_rst  = rst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= SCAN; idx <= '0; timer <= '0; rst_q <= '0;
    end else begin
      rst_q <= fire ? (N_INST'(1) << idx) : '0;
      case (st)
        SCAN:
          if (cur_need) begin
            st <= HOLD; timer <= '0;
          end else idx <= idx_nxt;
        HOLD:
          if (judge) begin
            timer <= '0;
            if (!cur_need) begin
              st <= SCAN; idx <= idx_nxt;
            end
          end else timer <= timer + 1'b1;
        default: st <= SCAN;
      endcase
    end

  for (genvar i = 0; i < N_INST; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= '0;
      else if (fire && idx == IW'(i) && cnt != '1) cnt <= cnt + 1'b1;
    assign retry_cnt[i*CNT_W +: CNT_W] = cnt;
  end
endmodule

module relock_supervisor_chk #(
  parameter int N_INST   = 4,
  parameter int WAIT_CYC = 4096,
  parameter int CNT_W    = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_INST-1:0]       mgr_rst,
  input logic [N_INST*CNT_W-1:0] retry_cnt
);
  int   gap;
  logic seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap <= 0; seen <= 1'b0;
    end else if (|mgr_rst) begin
      gap <= 0; seen <= 1'b1;
    end else if (gap < WAIT_CYC) gap <= gap + 1;

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mgr_rst));
  assert_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mgr_rst) |=> (mgr_rst == '0));
  assert_min_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mgr_rst) && seen) |-> (gap >= WAIT_CYC - 1));

  for (genvar i = 0; i < N_INST; i++) begin : g_a
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_cnt[i*CNT_W +: CNT_W] != $past(retry_cnt[i*CNT_W +: CNT_W])) |->
        (retry_cnt[i*CNT_W +: CNT_W] == $past(retry_cnt[i*CNT_W +: CNT_W]) + 1'b1));
    assert_count_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_cnt[i*CNT_W +: CNT_W] != $past(retry_cnt[i*CNT_W +: CNT_W])) |-> mgr_rst[i]);
  end
endmodule

bind relock_supervisor relock_supervisor_chk #(
  .N_INST(N_INST), .WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)
) u_chk (.clk(clk), .rst_n(rst_n), .mgr_rst(mgr_rst), .retry_cnt(retry_cnt));

// File: tb/sim_relock_supervisor.sv
`timescale 1ns/1ps
module sim_relock_supervisor;
  localparam int N = 4, F = 2, W = 16, CW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0]   lock_in = '1;
  logic [N*F-1:0] fault_in = '0;
  logic [N-1:0]   mgr_rst;
  logic [N*CW-1:0] retry_cnt;

  relock_supervisor #(.N_INST(N), .N_FLT(F), .WAIT_CYC(W), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .fault_in(fault_in),
    .mgr_rst(mgr_rst), .retry_cnt(retry_cnt));

  always #4 clk = ~clk;

  typedef struct { int idx; int gap; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0, seen = 0, last = 0;
  int heal_at [N] = '{default: -1};
  logic [N-1:0] clk_ok = '1;
  logic [N-1:0] prev = '0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_pulse(int idx, int gap);
    exp_t e; e.idx = idx; e.gap = gap; q.push_back(e);
  endtask

  task automatic wait_seen(int n);
    while (seen < n) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int cnt_of(int i);
    return int'(retry_cnt[i*CW +: CW]);
  endfunction

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < N; i++) if (heal_at[i] == cyc) lock_in[i] = 1'b1;
    if (rst_n) begin
      if (mgr_rst != '0) begin
        int p;
        exp_t e;
        p = 0;
        for (int i = 0; i < N; i++) if (mgr_rst[i]) p = i;
        chk($countones(mgr_rst) == 1, "R3 onehot", int'(mgr_rst), 1 << p);
        chk(prev == '0, "R3 width", int'(prev), 0);
        if (q.size() == 0) chk(0, "R5 unexpected pulse", p, -1);
        else begin
          e = q.pop_front();
          chk(p == e.idx, "R6 instance order", p, e.idx);
          if (e.gap != 0) chk(cyc - last == e.gap, "R4 retry spacing", cyc - last, e.gap);
        end
        last = cyc; seen++;
        if (clk_ok[p]) heal_at[p] = cyc + 3;
      end
      prev = mgr_rst;
    end
  end

  initial begin
    idle(5);
    rst_n = 1;
    idle(1);
    chk(mgr_rst == '0, "R1 reset pulse", int'(mgr_rst), 0);
    chk(retry_cnt == '0, "R1 reset count", int'(retry_cnt), 0);
    idle(50);
    chk(seen == 0, "R1 idle no pulse", seen, 0);

    expect_pulse(2, 0);
    fault_in[2*F + 1] = 1'b1;
    idle(5);
    fault_in[2*F + 1] = 1'b0;
    wait_seen(1);
    idle(40);
    chk(cnt_of(2) == 1, "R2 fault bit1 inst2 count", cnt_of(2), 1);

    expect_pulse(0, 0);
    fault_in[0] = 1'b1;
    idle(5);
    fault_in[0] = 1'b0;
    wait_seen(2);
    idle(40);
    chk(cnt_of(0) == 1, "R2 fault bit0 inst0 count", cnt_of(0), 1);
    chk(seen == 2, "R5 no retry after lock", seen, 2);

    clk_ok[1] = 1'b0;
    lock_in[1] = 1'b0;
    expect_pulse(1, 0);
    for (int k = 0; k < 4; k++) expect_pulse(1, W);
    expect_pulse(3, 0);
    expect_pulse(0, 0);
    wait_seen(6);
    chk(lock_in[1] == 1'b0, "R5 still clockless", int'(lock_in[1]), 0);
    clk_ok[1] = 1'b1;
    lock_in[3] = 1'b0;
    lock_in[0] = 1'b0;
    wait_seen(9);
    idle(100);
    chk(q.size() == 0, "R5 all queued pulses seen", q.size(), 0);
    chk(seen == 9, "R5 total pulses", seen, 9);
    chk(cnt_of(1) == 3, "R7 saturation inst1", cnt_of(1), 3);
    chk(cnt_of(3) == 1, "R7 count inst3", cnt_of(3), 1);
    chk(cnt_of(0) == 2, "R7 count inst0", cnt_of(0), 2);
    chk(cnt_of(2) == 1, "R7 count inst2 kept", cnt_of(2), 1);
    done = 1;
  end

  initial begin
    while (!done && cyc < 20000) @(negedge clk);
    if (!done) chk(0, "watchdog", cyc, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule